// File: doc/BRIEF.md
# Parallel EPROM Read Controller

This block sits on the host side of a parallel UV/OTP EPROM and turns a simple request into a complete device access. A request carries a word address, a byte/word choice and an identifier flag. The controller drives the device address, the active-low chip enable, the active-low output enable and the width select. It waits a programmed number of clock cycles until the device data is guaranteed valid, then captures it and returns a 16-bit result with a one-cycle done pulse.

In word mode a single access returns all 16 data lines, and the shared top pin is read as data bit 15. In byte mode the shared top pin becomes the least-significant address input. The controller performs two accesses: the first with that pin low, which gives the low byte, and the second with it high, which gives the high byte. It assembles the two bytes into one 16-bit result. Identifier mode raises a select line that an external high-voltage driver uses, forces every address bit above bit 0 to zero, and returns the 8-bit code in the low byte with the upper byte cleared.

After the final capture both enables return high so that the device drops to standby. The controller then waits a bus-release gap before it accepts a new request, which gives the device time to float its outputs.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: After reset, reqReady is 1, memCeN and memOeN are 1 and rspDone is 0.
- R2: A word-mode request (reqByteMode=0, reqIdent=0) drives memWordSel=1 and memAddr=reqAddr. It returns memDataIn[15:0], captured exactly SAMPLE_DLY = max(ADDR_DLY, OE_DLY) cycles after the accepting edge.
- R3: A byte-mode request drives memWordSel=0 and memTopDrvEn=1. It holds memTopOut=0 for the first access and memTopOut=1 for the second. It returns {second memDataIn[7:0], first memDataIn[7:0]}, and memDataIn[15:8] has no effect on the result.
- R4: In byte mode the second capture happens exactly ADDR_DLY cycles after the first, because memTopOut changed. The enables stay low between the two captures.
- R5: An identifier request drives memIdSel=1 and memWordSel=1, with memAddr bits above bit 0 at zero and bit 0 equal to reqAddr[0]. The result is {8'h00, memDataIn[7:0]}: 0x0020 for bit 0 low and 0x00B1 for bit 0 high.
- R6: Data is never captured before both the address delay and the output-enable delay have elapsed. memOeN is low only while memCeN is low.
- R7: rspDone is a single-cycle pulse. It is high in the cycle after the final capture edge, and rspData is valid while it is high.
- R8: From the accepting edge until the release gap ends, reqReady is 0 and further requests are ignored. memAddr stays stable while memCeN is low.
- R9: At the final capture edge memCeN and memOeN go high together. reqReady returns FLOAT_DLY cycles after that edge.
- R10: While idle (reqReady=1), memCeN and memOeN are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Controller idle and able to accept |
| reqAddr | input | ADDR_W | Word address |
| reqByteMode | input | 1 | 1 selects two byte accesses |
| reqIdent | input | 1 | 1 selects identifier read |
| rspDone | output | 1 | One-cycle result strobe |
| rspData | output | 16 | Assembled result |
| memAddr | output | ADDR_W | Device address lines |
| memTopOut | output | 1 | Value for shared top pin when it acts as address |
| memTopDrvEn | output | 1 | 1 when the host drives the shared top pin |
| memWordSel | output | 1 | Width select, 1 = 16-bit organisation |
| memIdSel | output | 1 | Request for the identifier voltage on the signature pin |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memDataIn | input | 16 | Device data lines; bit 15 is the shared top pin |

## Verification
Every result falls on a cycle fixed by the parameters. The done pulse comes SAMPLE_DLY+1 cycles after acceptance, or SAMPLE_DLY+ADDR_DLY+1 in byte mode. reqReady returns FLOAT_DLY cycles after the done edge. The bench models the device so that it drives a poison value until the address and output enable have been stable for their full delays. A capture that is one cycle early therefore returns the wrong data. The bench counts falling edges from the accepting edge and compares the exact cycle of rspDone and of reqReady against these sums. It never waits for an event without a count.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;
  typedef struct packed {
    logic accept;    // load request, start access
    logic capFirst;  // capture low byte, flip top address pin
    logic capFinal;  // capture result, release enables
  } ctlStrobe_t;
endpackage

// File: rtl/eprom_rd_ctl.sv
module eprom_rd_ctl
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_DLY  = 14,
  parameter int OE_DLY    = 7,
  parameter int FLOAT_DLY = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqByteMode,
  input  logic       reqIdent,
  output logic       reqReady,
  output ctlStrobe_t strobe
);
  localparam int SAMPLE_DLY = (ADDR_DLY > OE_DLY) ? ADDR_DLY : OE_DLY;
  localparam int MAX_DLY    = (SAMPLE_DLY > FLOAT_DLY) ? SAMPLE_DLY : FLOAT_DLY;
  localparam int CNT_W      = $clog2(MAX_DLY + 1) + 1;

  typedef enum logic [1:0] {IDLE, FIRST, SECOND, RELEASE} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             byteMode;

  assign reqReady = (state == IDLE);

  always_comb begin
    strobe = '0;
    case (state)
      IDLE:    strobe.accept = reqValid;
      FIRST: begin
        if (cnt == CNT_W'(SAMPLE_DLY)) begin
          strobe.capFirst = byteMode;
          strobe.capFinal = !byteMode;
        end
      end
      SECOND:  strobe.capFinal = (cnt == CNT_W'(ADDR_DLY));
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= IDLE;
      cnt      <= '0;
      byteMode <= 1'b0;
    end else begin
      case (state)
        IDLE: begin
          if (strobe.accept) begin
            state    <= FIRST;
            cnt      <= CNT_W'(1);
            byteMode <= reqByteMode && !reqIdent;
          end
        end
        FIRST: begin
          if (strobe.capFirst) begin
            state <= SECOND;
            cnt   <= CNT_W'(1);
          end else if (strobe.capFinal) begin
            state <= RELEASE;
            cnt   <= CNT_W'(1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SECOND: begin
          if (strobe.capFinal) begin
            state <= RELEASE;
            cnt   <= CNT_W'(1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CNT_W'(FLOAT_DLY)) state <= IDLE;
          else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/eprom_rd_dp.sv
module eprom_rd_dp
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqByteMode,
  input  logic              reqIdent,
  input  logic [15:0]       memDataIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memTopOut,
  output logic              memTopDrvEn,
  output logic              memWordSel,
  output logic              memIdSel,
  output logic              memCeN,
  output logic              memOeN,
  output logic              rspDone,
  output logic [15:0]       rspData
);
  logic [7:0]  loByte;
  logic [15:0] result;

  always_comb begin
    if (memIdSel)        result = {8'h00, memDataIn[7:0]};
    else if (!memWordSel) result = {memDataIn[7:0], loByte};
    else                 result = memDataIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr     <= '0;
      memTopOut   <= 1'b0;
      memTopDrvEn <= 1'b0;
      memWordSel  <= 1'b1;
      memIdSel    <= 1'b0;
      memCeN      <= 1'b1;
      memOeN      <= 1'b1;
      rspDone     <= 1'b0;
      rspData     <= '0;
      loByte      <= '0;
    end else begin
      rspDone <= 1'b0;
      if (strobe.accept) begin
        memIdSel    <= reqIdent;
        memWordSel  <= reqIdent || !reqByteMode;
        memTopDrvEn <= !reqIdent && reqByteMode;
        memTopOut   <= 1'b0;
        memAddr     <= reqIdent ? {{(ADDR_W-1){1'b0}}, reqAddr[0]} : reqAddr;
        memCeN      <= 1'b0;
        memOeN      <= 1'b0;
      end
      if (strobe.capFirst) begin
        loByte    <= memDataIn[7:0];
        memTopOut <= 1'b1;
      end
      if (strobe.capFinal) begin
        rspData <= result;
        rspDone <= 1'b1;
        memCeN  <= 1'b1;
        memOeN  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int ADDR_DLY  = 14,
  parameter int OE_DLY    = 7,
  parameter int FLOAT_DLY = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqByteMode,
  input  logic              reqIdent,
  output logic              rspDone,
  output logic [15:0]       rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memTopOut,
  output logic              memTopDrvEn,
  output logic              memWordSel,
  output logic              memIdSel,
  output logic              memCeN,
  output logic              memOeN,
  input  logic [15:0]       memDataIn
);
  ctlStrobe_t strobe;

  eprom_rd_ctl #(.ADDR_DLY(ADDR_DLY), .OE_DLY(OE_DLY), .FLOAT_DLY(FLOAT_DLY)) i_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqByteMode(reqByteMode),
    .reqIdent(reqIdent), .reqReady(reqReady), .strobe(strobe)
  );

  eprom_rd_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqByteMode(reqByteMode), .reqIdent(reqIdent), .memDataIn(memDataIn),
    .memAddr(memAddr), .memTopOut(memTopOut), .memTopDrvEn(memTopDrvEn),
    .memWordSel(memWordSel), .memIdSel(memIdSel), .memCeN(memCeN),
    .memOeN(memOeN), .rspDone(rspDone), .rspData(rspData)
  );
endmodule

// File: rtl/eprom_rd_chk.sv
module eprom_rd_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspDone,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memTopOut,
  input logic              memWordSel,
  input logic              memIdSel,
  input logic              memCeN,
  input logic              memOeN
);
  // R10
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memOeN));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R3
  top_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> !$fell(memTopOut));

  // R5
  ident_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memIdSel && !memCeN) |-> (memAddr[ADDR_W-1:1] == '0 && memWordSel));

  // R6
  oe_under_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memCeN);

  // R9
  release_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCeN) |-> !reqReady);
endmodule

bind eprom_rd_ctrl eprom_rd_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspDone(rspDone),
  .memAddr(memAddr), .memTopOut(memTopOut), .memWordSel(memWordSel),
  .memIdSel(memIdSel), .memCeN(memCeN), .memOeN(memOeN)
);

// File: tb/test_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module test_eprom_rd_ctrl;
  localparam int ADDR_W = 20;
  localparam int AD = 14;
  localparam int OD = 7;
  localparam int FD = 5;
  localparam int SD = (AD > OD) ? AD : OD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic reqByteMode = 1'b0;
  logic reqIdent = 1'b0;
  logic rspDone;
  logic [15:0] rspData;
  logic [ADDR_W-1:0] memAddr;
  logic memTopOut, memTopDrvEn, memWordSel, memIdSel, memCeN, memOeN;
  logic [15:0] memDataIn;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  eprom_rd_ctrl #(.ADDR_W(ADDR_W), .ADDR_DLY(AD), .OE_DLY(OD), .FLOAT_DLY(FD)) i_eprom_rd_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqByteMode(reqByteMode), .reqIdent(reqIdent),
    .rspDone(rspDone), .rspData(rspData), .memAddr(memAddr),
    .memTopOut(memTopOut), .memTopDrvEn(memTopDrvEn), .memWordSel(memWordSel),
    .memIdSel(memIdSel), .memCeN(memCeN), .memOeN(memOeN), .memDataIn(memDataIn)
  );

  // Device model: poison data until address and output enable have settled
  function automatic logic [15:0] wordAt(logic [ADDR_W-1:0] a);
    return a[15:0] ^ {a[19:16], 12'h6A5};
  endfunction

  logic [ADDR_W+1:0] lastKey = '0;
  int addrAge = 0;
  int oeAge = 0;
  always @(negedge clk) begin
    if ({memAddr, memTopOut, memTopDrvEn} != lastKey) addrAge <= 1;
    else if (addrAge < 1000) addrAge <= addrAge + 1;
    lastKey <= {memAddr, memTopOut, memTopDrvEn};
    if (memOeN || memCeN) oeAge <= 0;
    else if (oeAge < 1000) oeAge <= oeAge + 1;
  end

  always_comb begin
    logic [15:0] w;
    w = wordAt(memAddr);
    if (memCeN || memOeN || addrAge < AD || oeAge < OD) memDataIn = 16'hDEAD;
    else if (memIdSel)
      memDataIn = (memAddr[ADDR_W-1:1] != '0) ? 16'hDEAD :
                  (memAddr[0] ? 16'h00B1 : 16'h0020);
    else if (!memWordSel) memDataIn = {8'h5A, memTopOut ? w[15:8] : w[7:0]};
    else memDataIn = w;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One transaction; holdBusy keeps a different request valid while busy (R8)
  task automatic doRead(input logic [ADDR_W-1:0] a, input bit byteM, input bit ident,
                        input bit holdBusy, input logic [15:0] expData, input string req);
    int lat, doneAt, readyAt, n;
    logic [ADDR_W-1:0] expAddr;
    logic [15:0] got;
    lat = byteM && !ident ? SD + AD : SD;
    expAddr = ident ? {{(ADDR_W-1){1'b0}}, a[0]} : a;
    doneAt = -1; readyAt = -1; got = '0;
    @(negedge clk);
    check(reqReady == 1'b1, "R8 ready before request", reqReady, 1);
    reqValid = 1'b1; reqAddr = a; reqByteMode = byteM; reqIdent = ident;
    @(negedge clk);
    if (holdBusy) reqAddr = a ^ 20'h00F0F;
    else reqValid = 1'b0;
    n = 1;
    check(memAddr == expAddr, {req, " address"}, int'(memAddr), int'(expAddr));
    check(memWordSel == (ident || !byteM), {req, " width select"}, memWordSel, ident || !byteM);
    check(memIdSel == ident, "R5 ident select", memIdSel, ident);
    while (n < 400 && readyAt < 0) begin
      if (rspDone && doneAt < 0) begin doneAt = n; got = rspData; end
      if (reqReady) begin readyAt = n; reqValid = 1'b0; end
      if (doneAt < 0 && !memCeN && memAddr != expAddr) begin
        check(1'b0, "R8 address moved while busy", int'(memAddr), int'(expAddr));
      end
      if (readyAt < 0) begin @(negedge clk); n++; end
    end
    check(doneAt == lat + 1, "R7 done cycle", doneAt, lat + 1);
    check(got == expData, {req, " data"}, got, expData);
    check(readyAt == lat + FD + 1, "R9 release gap", readyAt, lat + FD + 1);
    check(memCeN && memOeN, "R10 standby after transaction", {memCeN, memOeN}, 3);
  endtask

  task automatic testReset();
    check(reqReady == 1'b1, "R1 ready", reqReady, 1);
    check(memCeN && memOeN, "R1 enables high", {memCeN, memOeN}, 3);
    check(rspDone == 1'b0, "R1 done low", rspDone, 0);
  endtask

  task automatic testWord();
    // R2 R6: any early capture returns 0xDEAD from the model
    doRead(20'h00000, 0, 0, 0, wordAt(20'h00000), "R2 word");
    doRead(20'hFFFFF, 0, 0, 0, wordAt(20'hFFFFF), "R2 word");
    doRead(20'h3A5C1, 0, 0, 0, wordAt(20'h3A5C1), "R6 word");
  endtask

  task automatic testByte();
    // R3 R4: two accesses, upper lines carry 0x5A which must not appear
    doRead(20'h12345, 1, 0, 0, wordAt(20'h12345), "R3 byte");
    doRead(20'hABCDE, 1, 0, 0, wordAt(20'hABCDE), "R4 byte");
  endtask

  task automatic testIdent();
    doRead(20'hFFFF0, 0, 1, 0, 16'h0020, "R5 ident lo");
    doRead(20'h00001, 1, 1, 0, 16'h00B1, "R5 ident hi");
  endtask

  task automatic testBusy();
    doRead(20'h0F0F0, 0, 0, 1, wordAt(20'h0F0F0), "R8 busy word");
    doRead(20'h55555, 1, 0, 1, wordAt(20'h55555), "R8 busy byte");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWord();
    testByte();
    testIdent();
    testBusy();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule